// File: doc/BRIEF.md
# Pinless power-on reset sequencer

This block produces the reset for the whole design from inside the chip. There is no reset pin. It runs on one internal clock. A short shift register gets its contents from register initial values when the device powers up: every bit is one. A zero enters the register on each rising edge. While the top bit is still one, the active-low reset `rst_no` is held asserted. When the last one has shifted out, the reset releases and never asserts again until power is cycled. An active-high copy, `rst_o`, is provided for logic that wants the opposite polarity.

The generator flops are not connected to the reset they produce, so the source can never clear itself. The reset can arrive at distant flops with large skew. For that reason a small startup machine passes through a parameterised number of settle states after release before it raises `ready_o`. Logic that acts on external inputs should wait for `ready_o`.

A demo register shows how a downstream flop uses the reset. It has an asynchronous active-low reset to a non-zero value (one by default) and otherwise samples `d_i` on every rising edge.

Top module: `por_seq_top`

## Requirements
- R1: At power-up, before any clock edge, rst_no is 0, rst_o is 1, ready_o is 0 and q_o equals RST_VAL (default 1).
- R2: rst_no stays 0 until the RST_CYCLES-th rising clock edge (default 4) and goes to 1 right after that edge, so reset is asserted for exactly RST_CYCLES clock cycles.
- R3: rst_o is always the logical inverse of rst_no.
- R4: Once rst_no has gone to 1, it stays 1 for every later cycle.
- R5: While rst_no is 0, q_o equals RST_VAL, whatever value d_i takes.
- R6: After release, q_o takes the value d_i had at each rising edge at which rst_no was already 1. The release edge itself does not capture.
- R7: ready_o is 0 while reset is asserted. It goes to 1 right after the SETTLE_STATES-th rising edge (default 3) following the release edge.
- R8: Once ready_o is 1, it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal free-running clock |
| d_i | input | DATA_W | Demo register data input |
| q_o | output | DATA_W | Demo register output, resets to RST_VAL |
| rst_no | output | 1 | Distributed active-low reset |
| rst_o | output | 1 | Active-high copy of the reset |
| ready_o | output | 1 | High once all settle states have passed after release |

## Verification
The assertions assume that the clock toggles from power-up and that the register initial values are honoured. Nothing else can start the sequence, and no input exists to restart it. They also assume that d_i is stable around each rising edge. The bench meets this by changing d_i only on falling edges, drawing it from a fixed-seed random source. The bench forces the value opposite to the reset value just before the release edge and just after it, so both the hold behaviour and the first capture are tested.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [0:0] {
    ST_SETTLE = 1'b0,
    ST_READY  = 1'b1
  } start_state_e;
endpackage

// File: rtl/por_shift_gen.sv
// Reset source: initial values only, never cleared by its own output.
module por_shift_gen #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk_i,
  output logic rst_no
);
  localparam int unsigned MSB = RST_CYCLES - 1;

  logic [MSB:0] sr_q = '1;

  always_ff @(posedge clk_i) begin
    sr_q <= sr_q << 1;
  end

  assign rst_no = ~sr_q[MSB];
endmodule

// File: rtl/por_settle_fsm.sv
module por_settle_fsm
  import por_pkg::*;
#(
  parameter int unsigned SETTLE_STATES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CNT_W = (SETTLE_STATES > 1) ? $clog2(SETTLE_STATES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_STATES - 1);

  start_state_e    state_q = ST_SETTLE;
  logic [CNT_W-1:0] cnt_q  = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETTLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SETTLE: begin
          if (cnt_q == LAST) state_q <= ST_READY;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_READY;
      endcase
    end
  end

  assign ready_o = (state_q == ST_READY);
endmodule

// File: rtl/por_demo_reg.sv
module por_demo_reg #(
  parameter int unsigned        DATA_W  = 1,
  parameter logic [DATA_W-1:0]  RST_VAL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q = RST_VAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/por_seq_top.sv
module por_seq_top #(
  parameter int unsigned       RST_CYCLES    = 4,
  parameter int unsigned       SETTLE_STATES = 3,
  parameter int unsigned       DATA_W        = 1,
  parameter logic [DATA_W-1:0] RST_VAL       = '1
) (
  input  logic              clk_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              rst_no,
  output logic              rst_o,
  output logic              ready_o
);
  logic rst_n;

  por_shift_gen #(.RST_CYCLES(RST_CYCLES)) u_gen (
    .clk_i  (clk_i),
    .rst_no (rst_n)
  );

  por_settle_fsm #(.SETTLE_STATES(SETTLE_STATES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .ready_o (ready_o)
  );

  por_demo_reg #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_demo (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (d_i),
    .q_o    (q_o)
  );

  assign rst_no = rst_n;
  assign rst_o  = ~rst_n;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
  parameter int unsigned       RST_CYCLES    = 4,
  parameter int unsigned       SETTLE_STATES = 3,
  parameter int unsigned       DATA_W        = 1,
  parameter logic [DATA_W-1:0] RST_VAL       = '1
) (
  input logic              clk_i,
  input logic [DATA_W-1:0] d_i,
  input logic [DATA_W-1:0] q_o,
  input logic              rst_no,
  input logic              rst_o,
  input logic              ready_o
);
  localparam int unsigned LO_W  = $clog2(RST_CYCLES + 2);
  localparam int unsigned REL_W = $clog2(SETTLE_STATES + 1);
  localparam logic [LO_W-1:0]  LO_MAX  = LO_W'(RST_CYCLES + 1);
  localparam logic [REL_W-1:0] REL_MAX = REL_W'(SETTLE_STATES);

  logic [LO_W-1:0]  lo_cnt  = '0;
  logic [REL_W-1:0] rel_cnt = '0;

  always_ff @(posedge clk_i) begin
    if (!rst_no && lo_cnt != LO_MAX)  lo_cnt  <= lo_cnt + 1'b1;
    if (rst_no && rel_cnt != REL_MAX) rel_cnt <= rel_cnt + 1'b1;
  end

  p_rst_len_r2: assert property (@(posedge clk_i)
    $rose(rst_no) |-> lo_cnt == LO_W'(RST_CYCLES));

  p_inverse_r3: assert property (@(posedge clk_i) rst_o == !rst_no);

  p_no_reassert_r4: assert property (@(posedge clk_i) rst_no |=> rst_no);

  p_q_hold_r5: assert property (@(posedge clk_i) !rst_no |-> q_o == RST_VAL);

  p_q_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_no)
    $past(rst_no) |-> q_o == $past(d_i));

  p_ready_time_r7: assert property (@(posedge clk_i) disable iff (!rst_no)
    ready_o == (rel_cnt == REL_MAX));

  p_ready_low_r7: assert property (@(posedge clk_i) !rst_no |-> !ready_o);

  p_ready_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_no)
    ready_o |=> ready_o);
endmodule

bind por_seq_top por_seq_chk #(
  .RST_CYCLES(RST_CYCLES), .SETTLE_STATES(SETTLE_STATES),
  .DATA_W(DATA_W), .RST_VAL(RST_VAL)
) u_chk (
  .clk_i(clk_i), .d_i(d_i), .q_o(q_o),
  .rst_no(rst_no), .rst_o(rst_o), .ready_o(ready_o)
);

// File: tb/tb_por_seq_top.sv
`timescale 1ns/1ps
module tb_por_seq_top;
  localparam int unsigned N      = 4;
  localparam int unsigned M      = 3;
  localparam int unsigned W      = 1;
  localparam logic [W-1:0] RV    = '1;
  localparam int unsigned NCYC   = 300;

  logic         clk_i = 1'b0;
  logic [W-1:0] d_i   = '0;
  logic [W-1:0] q_o;
  logic         rst_no, rst_o, ready_o;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  always #2 clk_i = ~clk_i;

  por_seq_top #(.RST_CYCLES(N), .SETTLE_STATES(M), .DATA_W(W), .RST_VAL(RV)) dut (
    .clk_i(clk_i), .d_i(d_i), .q_o(q_o),
    .rst_no(rst_no), .rst_o(rst_o), .ready_o(ready_o)
  );

  function automatic logic exp_rst_n(input int k);
    return k >= N;
  endfunction

  function automatic logic exp_ready(input int k);
    return k >= N + M;
  endfunction

  function automatic logic [W-1:0] exp_q(input int k, input logic [W-1:0] d_prev);
    return (k <= N) ? RV : d_prev;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic [W-1:0] d_prev;
    int rel_k;
    int rdy_k;
    rel_k  = -1;
    rdy_k  = -1;
    d_prev = '0;
    void'($urandom(32'h5eed_0042));
    #1;
    chk("R1 rst_no", rst_no, 0);
    chk("R1 rst_o", rst_o, 1);
    chk("R1 ready_o", ready_o, 0);
    chk("R1 q_o", q_o, RV);
    d_i = ~RV;  // held opposite during reset: R5
    d_prev = d_i;
    for (int k = 1; k <= NCYC; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R2 rst_no", rst_no, exp_rst_n(k));
      chk("R3 rst_o", rst_o, !rst_no);
      if (k > N) chk("R4 rst_no", rst_no, 1);
      if (k <= N) chk("R5 q_o", q_o, RV);
      else        chk("R6 q_o", q_o, exp_q(k, d_prev));
      chk("R7 ready_o", ready_o, exp_ready(k));
      if (k > N + M) chk("R8 ready_o", ready_o, 1);
      if (rel_k < 0 && rst_no)  rel_k = k;
      if (rdy_k < 0 && ready_o) rdy_k = k;
      if (k == N - 1 || k == N) d_i = ~RV;
      else if (k < N)           d_i = W'($urandom);
      else if (k == N + 1)      d_i = RV;
      else                      d_i = W'($urandom);
      d_prev = d_i;
    end
    chk("R2 reset-low cycles", rel_k, N);
    chk("R7 release-to-ready cycles", rdy_k - rel_k, M);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule